// File: doc/BRIEF.md
# Dual-Port Semaphore Bank

This block holds eight single-bit lock flags that two independent ports, called left and right, use to coordinate ownership of a shared resource. A port picks a flag with a 3-bit address. It then either tries to take the flag by writing 0 on its write-data bit, or gives the flag up by writing 1. A read returns the flag as this port sees it, copied onto every bit of the 16-bit read bus. A reading of 0 means this port holds the token. A reading of 1 means it does not.

A flag has at most one owner. Suppose one port asks for a flag while the other port holds it. The request is not granted, but the flag remembers it. When the holder later releases the flag, the token goes straight to the waiting port and the flag never passes through the free state. All state is held in registers on one clock with a synchronous active-high reset. A write takes effect at the clock edge. Reads are combinational from the registered state.

Top module: `dp_sema_bank`

## Requirements
- R1: After reset all eight flags are free and no request is waiting, so a read of any flag from either port returns 16'hFFFF.
- R2: A port accesses the bank only when its semaphore select is high and either its chip enable is low or both of its byte selects are low. In every other case a write changes no flag and the read bus is 16'h0000. This includes chip enable and a byte select high together with semaphore select.
- R3: A valid read, which is an access with the write strobe low, drives all 16 bits with the same value: 0 if the reading port owns the addressed flag, 1 otherwise.
- R4: Writing 0 to a free flag makes the writing port its owner from the next cycle. That port then reads 0 and the other port reads 1.
- R5: A write of 0 from the non-owning port leaves both ports' reads unchanged while the owner holds the flag.
- R6: The owner writing 1 while the other port has a waiting request hands the flag to the waiting port on that edge. This includes a request made in the same cycle.
- R7: The owner writing 1 with no request waiting frees the flag, so both ports read 1.
- R8: When both ports write 0 to the same free flag in the same cycle, the left port becomes owner and the right port's request is kept as waiting.
- R9: A waiting port that writes 1 before it is granted withdraws its request. A later release by the owner then frees the flag.
- R10: The eight flags are independent. An operation on one address changes no other flag.
- R11: The owner writing 0 to a flag it already holds has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_addr | input | 3 | Left flag address |
| l_sem_sel | input | 1 | Left semaphore select, active high |
| l_chip_en | input | 1 | Left array chip enable, active high |
| l_upper_sel | input | 1 | Left upper byte select, active high |
| l_lower_sel | input | 1 | Left lower byte select, active high |
| l_wr_en | input | 1 | Left write strobe, active high |
| l_wdat0 | input | 1 | Left write data bit (0 = take, 1 = release) |
| l_rdata | output | 16 | Left read data |
| r_addr | input | 3 | Right flag address |
| r_sem_sel | input | 1 | Right semaphore select, active high |
| r_chip_en | input | 1 | Right array chip enable, active high |
| r_upper_sel | input | 1 | Right upper byte select, active high |
| r_lower_sel | input | 1 | Right lower byte select, active high |
| r_wr_en | input | 1 | Right write strobe, active high |
| r_wdat0 | input | 1 | Right write data bit (0 = take, 1 = release) |
| r_rdata | output | 16 | Right read data |

## Verification
Two functions can fall in the same cycle. The first is a grant decided by the tie rule, where both ports write 0 to one free flag on the same edge. The second is an owner's release meeting a request from the other side, where the holder writes 1 while the other port writes 0 to the same address. The bench drives both ports in the same cycle for each case. It then reads the flag from both ports over the following cycles. This shows who was granted and whether the loser's request survived to be served by a later release. Every cycle's read buses are compared against a behavioural model of ownership and waiting requests.

// File: rtl/sema_pkg.sv
package sema_pkg;

    localparam int SEM_FLAGS  = 8;
    localparam int SEM_DATA_W = 16;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   wait_l;
        logic   wait_r;
    } flag_state_t;

    typedef struct packed {
        logic take;
        logic drop;
    } side_cmd_t;

    // valid semaphore access: select high with array path idle
    function automatic logic sem_access(input logic sel, input logic ce,
                                        input logic ub, input logic lb);
        return sel && (!ce || (!ub && !lb));
    endfunction

    // pending request after this cycle's command from the waiting side
    function automatic logic next_wait(input logic cur, input side_cmd_t c);
        if (c.take)
            return 1'b1;
        if (c.drop)
            return 1'b0;
        return cur;
    endfunction

endpackage

// File: rtl/sema_port_dec.sv
module sema_port_dec
    import sema_pkg::*;
#(
    parameter int NUM_FLAGS = SEM_FLAGS,
    parameter int ADDR_W    = $clog2(NUM_FLAGS)
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 sem_sel,
    input  logic                 chip_en,
    input  logic                 upper_sel,
    input  logic                 lower_sel,
    input  logic                 wr_en,
    input  logic                 wdat0,
    output side_cmd_t            cmd [NUM_FLAGS],
    output logic                 rd_en
);

    logic acc;
    logic wr;

    always_comb begin
        acc   = sem_access(sem_sel, chip_en, upper_sel, lower_sel);
        wr    = acc && wr_en;
        rd_en = acc && !wr_en;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
        always_comb begin
            cmd[g].take = wr && !wdat0 && (addr == IDX);
            cmd[g].drop = wr &&  wdat0 && (addr == IDX);
        end
    end

endmodule

// File: rtl/sema_flag_cell.sv
module sema_flag_cell
    import sema_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  side_cmd_t l_cmd,
    input  side_cmd_t r_cmd,
    output logic      own_l,
    output logic      own_r
);

    flag_state_t cur;
    flag_state_t nxt;
    logic        wl_eff;
    logic        wr_eff;

    always_comb begin
        wl_eff = next_wait(cur.wait_l, l_cmd);
        wr_eff = next_wait(cur.wait_r, r_cmd);
        nxt    = cur;
        case (cur.owner)
            OWN_NONE: begin
                nxt.wait_l = 1'b0;
                nxt.wait_r = 1'b0;
                if (l_cmd.take) begin
                    nxt.owner  = OWN_LEFT;
                    nxt.wait_r = r_cmd.take;
                end else if (r_cmd.take) begin
                    nxt.owner  = OWN_RIGHT;
                end
            end
            OWN_LEFT: begin
                nxt.wait_l = 1'b0;
                if (l_cmd.drop) begin
                    nxt.owner  = wr_eff ? OWN_RIGHT : OWN_NONE;
                    nxt.wait_r = 1'b0;
                end else begin
                    nxt.wait_r = wr_eff;
                end
            end
            OWN_RIGHT: begin
                nxt.wait_r = 1'b0;
                if (r_cmd.drop) begin
                    nxt.owner  = wl_eff ? OWN_LEFT : OWN_NONE;
                    nxt.wait_l = 1'b0;
                end else begin
                    nxt.wait_l = wl_eff;
                end
            end
            default: begin
                nxt.owner  = OWN_NONE;
                nxt.wait_l = 1'b0;
                nxt.wait_r = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.owner  <= OWN_NONE;
            cur.wait_l <= 1'b0;
            cur.wait_r <= 1'b0;
        end else begin
            cur <= nxt;
        end
    end

    always_comb begin
        own_l = (cur.owner == OWN_LEFT);
        own_r = (cur.owner == OWN_RIGHT);
    end

endmodule

// File: rtl/sema_read_view.sv
module sema_read_view
    import sema_pkg::*;
#(
    parameter int NUM_FLAGS = SEM_FLAGS,
    parameter int DATA_W    = SEM_DATA_W,
    parameter int ADDR_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_FLAGS-1:0] own_v,
    output logic [DATA_W-1:0]    rdata
);

    logic held;

    always_comb begin
        held  = own_v[addr];
        rdata = rd_en ? {DATA_W{~held}} : '0;
    end

endmodule

// File: rtl/dp_sema_bank.sv
module dp_sema_bank
    import sema_pkg::*;
#(
    parameter int NUM_FLAGS = SEM_FLAGS,
    parameter int DATA_W    = SEM_DATA_W,
    localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_sem_sel,
    input  logic              l_chip_en,
    input  logic              l_upper_sel,
    input  logic              l_lower_sel,
    input  logic              l_wr_en,
    input  logic              l_wdat0,
    output logic [DATA_W-1:0] l_rdata,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_sem_sel,
    input  logic              r_chip_en,
    input  logic              r_upper_sel,
    input  logic              r_lower_sel,
    input  logic              r_wr_en,
    input  logic              r_wdat0,
    output logic [DATA_W-1:0] r_rdata
);

    side_cmd_t            l_cmd [NUM_FLAGS];
    side_cmd_t            r_cmd [NUM_FLAGS];
    logic                 l_rd;
    logic                 r_rd;
    logic [NUM_FLAGS-1:0] own_l_vec;
    logic [NUM_FLAGS-1:0] own_r_vec;

    sema_port_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_l (
        .addr(l_addr), .sem_sel(l_sem_sel), .chip_en(l_chip_en),
        .upper_sel(l_upper_sel), .lower_sel(l_lower_sel),
        .wr_en(l_wr_en), .wdat0(l_wdat0), .cmd(l_cmd), .rd_en(l_rd)
    );

    sema_port_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_r (
        .addr(r_addr), .sem_sel(r_sem_sel), .chip_en(r_chip_en),
        .upper_sel(r_upper_sel), .lower_sel(r_lower_sel),
        .wr_en(r_wr_en), .wdat0(r_wdat0), .cmd(r_cmd), .rd_en(r_rd)
    );

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_cell
        sema_flag_cell u_cell (
            .clk(clk), .rst(rst),
            .l_cmd(l_cmd[f]), .r_cmd(r_cmd[f]),
            .own_l(own_l_vec[f]), .own_r(own_r_vec[f])
        );
    end

    sema_read_view #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_view_l (
        .rd_en(l_rd), .addr(l_addr), .own_v(own_l_vec), .rdata(l_rdata)
    );

    sema_read_view #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_view_r (
        .rd_en(r_rd), .addr(r_addr), .own_v(own_r_vec), .rdata(r_rdata)
    );

endmodule

// File: rtl/dp_sema_bank_chk.sv
module dp_sema_bank_chk
    import sema_pkg::*;
#(
    parameter int NUM_FLAGS = SEM_FLAGS,
    parameter int DATA_W    = SEM_DATA_W,
    parameter int ADDR_W    = $clog2(NUM_FLAGS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    l_addr,
    input logic                 l_sem_sel,
    input logic                 l_chip_en,
    input logic                 l_upper_sel,
    input logic                 l_lower_sel,
    input logic                 l_wr_en,
    input logic                 l_wdat0,
    input logic [DATA_W-1:0]    l_rdata,
    input logic [ADDR_W-1:0]    r_addr,
    input logic                 r_sem_sel,
    input logic                 r_chip_en,
    input logic                 r_upper_sel,
    input logic                 r_lower_sel,
    input logic                 r_wr_en,
    input logic                 r_wdat0,
    input logic [DATA_W-1:0]    r_rdata,
    input logic [NUM_FLAGS-1:0] own_l,
    input logic [NUM_FLAGS-1:0] own_r
);

    logic l_ok, r_ok, l_w0, l_w1, r_w0, r_w1, l_rd, r_rd;

    always_comb begin
        l_ok = sem_access(l_sem_sel, l_chip_en, l_upper_sel, l_lower_sel);
        r_ok = sem_access(r_sem_sel, r_chip_en, r_upper_sel, r_lower_sel);
        l_w0 = l_ok && l_wr_en && !l_wdat0;
        l_w1 = l_ok && l_wr_en &&  l_wdat0;
        r_w0 = r_ok && r_wr_en && !r_wdat0;
        r_w1 = r_ok && r_wr_en &&  r_wdat0;
        l_rd = l_ok && !l_wr_en;
        r_rd = r_ok && !r_wr_en;
    end

    assert_reset_free_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (own_l == '0 && own_r == '0));

    assert_no_write_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!(l_ok && l_wr_en) && !(r_ok && r_wr_en)) |=> ($stable(own_l) && $stable(own_r)));

    assert_read_left_R3: assert property (@(posedge clk) disable iff (rst)
        l_rd |-> (l_rdata == (own_l[l_addr] ? {DATA_W{1'b0}} : {DATA_W{1'b1}})));

    assert_read_right_R3: assert property (@(posedge clk) disable iff (rst)
        r_rd |-> (r_rdata == (own_r[r_addr] ? {DATA_W{1'b0}} : {DATA_W{1'b1}})));

    assert_take_free_left_R4: assert property (@(posedge clk) disable iff (rst)
        (l_w0 && !own_l[l_addr] && !own_r[l_addr]) |=> own_l[$past(l_addr)]);

    assert_take_free_right_R4: assert property (@(posedge clk) disable iff (rst)
        (r_w0 && !own_l[r_addr] && !own_r[r_addr] && !(l_w0 && l_addr == r_addr))
        |=> own_r[$past(r_addr)]);

    assert_nonowner_left_R5: assert property (@(posedge clk) disable iff (rst)
        (l_w0 && own_r[l_addr] && !(r_w1 && r_addr == l_addr)) |=> own_r[$past(l_addr)]);

    assert_release_left_R7: assert property (@(posedge clk) disable iff (rst)
        (l_w1 && own_l[l_addr]) |=> !own_l[$past(l_addr)]);

    assert_tie_left_R8: assert property (@(posedge clk) disable iff (rst)
        (l_w0 && r_w0 && l_addr == r_addr && !own_l[l_addr] && !own_r[l_addr])
        |=> (own_l[$past(l_addr)] && !own_r[$past(l_addr)]));

endmodule

bind dp_sema_bank dp_sema_bank_chk #(
    .NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst),
    .l_addr(l_addr), .l_sem_sel(l_sem_sel), .l_chip_en(l_chip_en),
    .l_upper_sel(l_upper_sel), .l_lower_sel(l_lower_sel),
    .l_wr_en(l_wr_en), .l_wdat0(l_wdat0), .l_rdata(l_rdata),
    .r_addr(r_addr), .r_sem_sel(r_sem_sel), .r_chip_en(r_chip_en),
    .r_upper_sel(r_upper_sel), .r_lower_sel(r_lower_sel),
    .r_wr_en(r_wr_en), .r_wdat0(r_wdat0), .r_rdata(r_rdata),
    .own_l(own_l_vec), .own_r(own_r_vec)
);

// File: tb/dp_sema_bank_bench.sv
module dp_sema_bank_bench;

    localparam int OP_IDLE  = 0;
    localparam int OP_RD    = 1;
    localparam int OP_W0    = 2;
    localparam int OP_W1    = 3;
    localparam int OP_BAD   = 4; // chip enable + byte select + sem select, write 0
    localparam int OP_ALT   = 5; // chip enable high, both byte selects low, write 0
    localparam int OP_NOSEL = 6; // sem select low, write 0

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  l_addr = '0, r_addr = '0;
    logic        l_sem_sel = 0, l_chip_en = 0, l_upper_sel = 0, l_lower_sel = 0, l_wr_en = 0, l_wdat0 = 0;
    logic        r_sem_sel = 0, r_chip_en = 0, r_upper_sel = 0, r_lower_sel = 0, r_wr_en = 0, r_wdat0 = 0;
    logic [15:0] l_rdata, r_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model: 0 free, 1 left owns, 2 right owns
    int owner  [8];
    bit wait_l [8];
    bit wait_r [8];

    always #10 clk = ~clk;

    dp_sema_bank u_dp_sema_bank (
        .clk(clk), .rst(rst),
        .l_addr(l_addr), .l_sem_sel(l_sem_sel), .l_chip_en(l_chip_en),
        .l_upper_sel(l_upper_sel), .l_lower_sel(l_lower_sel),
        .l_wr_en(l_wr_en), .l_wdat0(l_wdat0), .l_rdata(l_rdata),
        .r_addr(r_addr), .r_sem_sel(r_sem_sel), .r_chip_en(r_chip_en),
        .r_upper_sel(r_upper_sel), .r_lower_sel(r_lower_sel),
        .r_wr_en(r_wr_en), .r_wdat0(r_wdat0), .r_rdata(r_rdata)
    );

    function automatic bit op_write(int op);
        return op == OP_W0 || op == OP_W1 || op == OP_ALT;
    endfunction

    function automatic logic [15:0] expect_rd(int op, int a, int me);
        if (op != OP_RD) return 16'h0000;
        return (owner[a] == me) ? 16'h0000 : 16'hFFFF;
    endfunction

    task automatic set_port(bit left, int op, int a);
        logic s, ce, ub, lb, we, d;
        s = 1; ce = 0; ub = 0; lb = 0; we = 0; d = 0;
        case (op)
            OP_IDLE:  s = 0;
            OP_RD:    ;
            OP_W0:    we = 1;
            OP_W1:    begin we = 1; d = 1; end
            OP_BAD:   begin ce = 1; ub = 1; we = 1; end
            OP_ALT:   begin ce = 1; we = 1; end
            OP_NOSEL: begin s = 0; we = 1; end
            default:  s = 0;
        endcase
        if (left) begin
            l_addr = 3'(a); l_sem_sel = s; l_chip_en = ce; l_upper_sel = ub;
            l_lower_sel = lb; l_wr_en = we; l_wdat0 = d;
        end else begin
            r_addr = 3'(a); r_sem_sel = s; r_chip_en = ce; r_upper_sel = ub;
            r_lower_sel = lb; r_wr_en = we; r_wdat0 = d;
        end
    endtask

    task automatic model_update(int lop, int la, int rop, int ra);
        for (int f = 0; f < 8; f++) begin
            bit lt, ld, rt, rd, wl, wr;
            lt = op_write(lop) && lop != OP_W1 && la == f;
            ld = lop == OP_W1 && la == f;
            rt = op_write(rop) && rop != OP_W1 && ra == f;
            rd = rop == OP_W1 && ra == f;
            wl = lt ? 1'b1 : (ld ? 1'b0 : wait_l[f]);
            wr = rt ? 1'b1 : (rd ? 1'b0 : wait_r[f]);
            if (owner[f] == 0) begin
                wait_l[f] = 0; wait_r[f] = 0;
                if (lt) begin owner[f] = 1; wait_r[f] = rt; end
                else if (rt) owner[f] = 2;
            end else if (owner[f] == 1) begin
                wait_l[f] = 0;
                if (ld) begin owner[f] = wr ? 2 : 0; wait_r[f] = 0; end
                else wait_r[f] = wr;
            end else begin
                wait_r[f] = 0;
                if (rd) begin owner[f] = wl ? 1 : 0; wait_l[f] = 0; end
                else wait_l[f] = wl;
            end
        end
    endtask

    // one clock: drive after negedge, compare mid-cycle, advance model at edge
    task automatic cyc(int lop, int la, int rop, int ra, string tag);
        logic [15:0] el, er;
        @(negedge clk);
        set_port(1, lop, la);
        set_port(0, rop, ra);
        #2;
        el = expect_rd(lop, la, 1);
        er = expect_rd(rop, ra, 2);
        checks++;
        if (l_rdata !== el) begin
            fails++;
            $display("FAIL %s left flag %0d: actual %h expected %h", tag, la, l_rdata, el);
        end
        checks++;
        if (r_rdata !== er) begin
            fails++;
            $display("FAIL %s right flag %0d: actual %h expected %h", tag, ra, r_rdata, er);
        end
        model_update(lop, la, rop, ra);
    endtask

    task automatic read_both(int a, string tag);
        cyc(OP_RD, a, OP_RD, a, tag);
    endtask

    initial begin
        for (int f = 0; f < 8; f++) begin owner[f] = 0; wait_l[f] = 0; wait_r[f] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int f = 0; f < 8; f++) read_both(f, "R1");

        cyc(OP_W0, 0, OP_IDLE, 0, "R4");
        read_both(0, "R4");
        cyc(OP_W0, 0, OP_RD, 0, "R11");
        read_both(0, "R11");
        cyc(OP_RD, 0, OP_W0, 0, "R5");
        read_both(0, "R5");
        cyc(OP_W1, 0, OP_IDLE, 0, "R6");
        read_both(0, "R6");
        cyc(OP_IDLE, 0, OP_W1, 0, "R7");
        read_both(0, "R7");

        cyc(OP_W0, 3, OP_W0, 3, "R8");
        read_both(3, "R8");
        cyc(OP_W1, 3, OP_RD, 3, "R8");
        read_both(3, "R8");
        cyc(OP_IDLE, 3, OP_W1, 3, "R7");
        read_both(3, "R7");

        cyc(OP_W0, 5, OP_IDLE, 0, "R9");
        cyc(OP_RD, 5, OP_W0, 5, "R9");
        cyc(OP_RD, 5, OP_W1, 5, "R9");
        cyc(OP_W1, 5, OP_RD, 5, "R9");
        read_both(5, "R9");

        cyc(OP_BAD, 1, OP_NOSEL, 1, "R2");
        read_both(1, "R2");
        cyc(OP_RD, 1, OP_ALT, 1, "R2");
        read_both(1, "R2");
        cyc(OP_IDLE, 1, OP_W1, 1, "R2");

        cyc(OP_W0, 6, OP_IDLE, 0, "R6");
        cyc(OP_W1, 6, OP_W0, 6, "R6");
        read_both(6, "R6");
        cyc(OP_RD, 6, OP_W1, 6, "R7");

        for (int f = 0; f < 8; f++) begin
            if (f % 2 == 0) cyc(OP_W0, f, OP_IDLE, 0, "R10");
            else            cyc(OP_IDLE, 0, OP_W0, f, "R10");
        end
        for (int f = 0; f < 8; f++) read_both(f, "R10");
        for (int f = 0; f < 8; f++) cyc(OP_RD, f, OP_RD, 7 - f, "R3");

        cyc(OP_IDLE, 0, OP_IDLE, 0, "R2");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule